// File: doc/BRIEF.md
# Serial Port Error Flag Controller

This block collects the error conditions of a synchronous serial port into four sticky status flags and one shared error interrupt request. Phase, transmit and baud-rate errors are found elsewhere and arrive here as single-cycle event pulses. The receive-overrun error is found inside the block. It watches a frame-complete strobe and a buffer-read strobe, and it keeps the last received frame in a receive buffer.

Each error always sets its own flag. The shared interrupt request rises only for errors whose enable bit is set. The flags are cleared by software alone, through a write-one-to-clear port. The interrupt request has its own clear strobe, which the interrupt service path pulses. This split lets software take some errors by interrupt and poll the others. Transmit and baud-rate events count only while the port is in slave mode.

Top module: `serr_ctrl`

## Requirements
- R1: A synchronous active-high reset clears all four flags, the interrupt request, the receive buffer and the unread state. After reset, two frames in a row raise no receive error until the second frame arrives unread on top of the first.
- R2: A frame completing while the previous frame is still unread, with no buffer read in that cycle, sets flag bit 0 (receive error) on the next clock edge.
- R3: Every completed frame loads its data into the receive buffer on the next clock edge. The old contents are lost, including on a receive error.
- R4: A frame-complete and a buffer-read in the same cycle raise no receive error, and the new frame is left unread.
- R5: A phase-error pulse sets flag bit 1 in both master mode and slave mode.
- R6: A transmit-error pulse sets flag bit 2 and a baud-rate-error pulse sets flag bit 3 only when the slave-mode input is 1. With the slave-mode input at 0 (master mode), these pulses leave the flags unchanged.
- R7: Flags stay set until software writes a 1 to the matching bit of the clear port. Clear bits written as 0 leave their flags as they are.
- R8: When a flag is set and cleared in the same cycle, the flag ends up set.
- R9: The interrupt request rises one cycle after an error whose enable bit (same bit order as the flags) is 1. Errors whose enable bit is 0 do not raise it.
- R10: The interrupt request holds until its clear strobe. Clearing flags does not drop it, and clearing it does not touch the flags.
- R11: When an enabled error and the interrupt clear arrive in the same cycle, the interrupt request ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slaveMode | input | 1 | 1 = slave mode, 0 = master mode |
| errEnable | input | 4 | Interrupt enable per error, bit order as flags |
| evPhase | input | 1 | Phase-error event pulse |
| evTx | input | 1 | Transmit-error event pulse (slave only) |
| evBaud | input | 1 | Baud-rate-error event pulse (slave only) |
| frameDone | input | 1 | Frame-complete strobe |
| frameData | input | DATA_W | Data of the completed frame |
| bufRead | input | 1 | Receive buffer read strobe |
| clrFlags | input | 4 | Write-one-to-clear of the flags |
| clrIrq | input | 1 | Clear of the interrupt request |
| flags | output | 4 | Sticky flags: 0 receive, 1 phase, 2 transmit, 3 baud |
| errIrq | output | 1 | Shared error interrupt request |
| rxBuf | output | DATA_W | Receive buffer contents |

## Verification
Three pairs of functions can fall in the same cycle: frame completion and buffer read, a flag set and its software clear, and an enabled error and the interrupt clear. The bench drives each pair of strobes inside one clock period. It then reads the flags, the interrupt request and a follow-up frame to judge the result. A merged read and frame must leave no error while still marking the new frame unread. In both of the other collisions the set must win.

// File: rtl/serr_pkg.sv
package serr_pkg;
  localparam int ERR_N = 4;
  localparam int ERR_RX = 0;
  localparam int ERR_PH = 1;
  localparam int ERR_TX = 2;
  localparam int ERR_BD = 3;
  localparam logic [ERR_N-1:0] SLAVE_ONLY = (1 << ERR_TX) | (1 << ERR_BD);

  typedef struct packed {
    logic [ERR_N-1:0] setFlags;
    logic             loadBuf;
    logic             markRead;
  } serr_strobe_t;
endpackage

// File: rtl/serr_control.sv
module serr_control
  import serr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             slaveMode,
  input  logic [ERR_N-1:0] errEnable,
  input  logic             evPhase,
  input  logic             evTx,
  input  logic             evBaud,
  input  logic             frameDone,
  input  logic             bufRead,
  input  logic             clrIrq,
  input  logic             unread,
  output serr_strobe_t     strobe,
  output logic             errIrq
);
  logic [ERR_N-1:0] rawEvents;
  logic [ERR_N-1:0] modeMask;
  logic [ERR_N-1:0] setVec;
  logic             overrun;
  logic             irqQ;

  always_comb begin
    overrun            = frameDone & unread & ~bufRead;
    rawEvents          = '0;
    rawEvents[ERR_RX]  = overrun;
    rawEvents[ERR_PH]  = evPhase;
    rawEvents[ERR_TX]  = evTx;
    rawEvents[ERR_BD]  = evBaud;
    modeMask           = slaveMode ? '1 : ~SLAVE_ONLY;
    setVec             = rawEvents & modeMask;
    strobe.setFlags    = setVec;
    strobe.loadBuf     = frameDone;
    strobe.markRead    = bufRead;
  end

  always_ff @(posedge clk) begin
    if (rst)                      irqQ <= 1'b0;
    else if (|(setVec & errEnable)) irqQ <= 1'b1;
    else if (clrIrq)              irqQ <= 1'b0;
  end

  assign errIrq = irqQ;

  // R10: request holds until its clear
  p_irq_hold_r10: assert property (@(posedge clk) disable iff (rst)
    irqQ && !clrIrq |=> irqQ);
  // R11: enabled error beats a simultaneous clear
  p_irq_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
    evPhase && errEnable[ERR_PH] |=> irqQ);
endmodule

// File: rtl/serr_datapath.sv
module serr_datapath
  import serr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  serr_strobe_t      strobe,
  input  logic [DATA_W-1:0] frameData,
  input  logic [ERR_N-1:0]  clrFlags,
  output logic [ERR_N-1:0]  flags,
  output logic [DATA_W-1:0] rxBuf,
  output logic              unread
);
  logic [ERR_N-1:0]  flagQ;
  logic [DATA_W-1:0] bufQ;
  logic              unreadQ;

  for (genvar i = 0; i < ERR_N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                     flagQ[i] <= 1'b0;
      else if (strobe.setFlags[i]) flagQ[i] <= 1'b1;
      else if (clrFlags[i])        flagQ[i] <= 1'b0;
    end
    // R7: sticky unless cleared
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
      flagQ[i] && !clrFlags[i] |=> flagQ[i]);
    // R8: set wins over clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
      strobe.setFlags[i] |=> flagQ[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)                 bufQ <= '0;
    else if (strobe.loadBuf) bufQ <= frameData;
  end

  always_ff @(posedge clk) begin
    if (rst)                  unreadQ <= 1'b0;
    else if (strobe.loadBuf)  unreadQ <= 1'b1;
    else if (strobe.markRead) unreadQ <= 1'b0;
  end

  assign flags  = flagQ;
  assign rxBuf  = bufQ;
  assign unread = unreadQ;

  // R3: each frame lands in the buffer
  p_overwrite_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.loadBuf |=> bufQ == $past(frameData));
  // R4: new frame stays unread
  p_new_unread_r4: assert property (@(posedge clk) disable iff (rst)
    strobe.loadBuf |=> unreadQ);
endmodule

// File: rtl/serr_ctrl.sv
module serr_ctrl
  import serr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slaveMode,
  input  logic [3:0]        errEnable,
  input  logic              evPhase,
  input  logic              evTx,
  input  logic              evBaud,
  input  logic              frameDone,
  input  logic [DATA_W-1:0] frameData,
  input  logic              bufRead,
  input  logic [3:0]        clrFlags,
  input  logic              clrIrq,
  output logic [3:0]        flags,
  output logic              errIrq,
  output logic [DATA_W-1:0] rxBuf
);
  serr_strobe_t strobe;
  logic         unread;

  serr_control u_ctl (
    .clk(clk), .rst(rst), .slaveMode(slaveMode), .errEnable(errEnable),
    .evPhase(evPhase), .evTx(evTx), .evBaud(evBaud),
    .frameDone(frameDone), .bufRead(bufRead), .clrIrq(clrIrq),
    .unread(unread), .strobe(strobe), .errIrq(errIrq)
  );

  serr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .frameData(frameData),
    .clrFlags(clrFlags), .flags(flags), .rxBuf(rxBuf), .unread(unread)
  );

  // R2: overrun sets the receive flag
  p_overrun_flag_r2: assert property (@(posedge clk) disable iff (rst)
    frameDone && unread && !bufRead |=> flags[ERR_RX]);
  // R4: merged read and frame raise no error
  p_collide_no_err_r4: assert property (@(posedge clk) disable iff (rst)
    frameDone && bufRead && !flags[ERR_RX] |=> !flags[ERR_RX]);
  // R6: master mode ignores slave-only events
  p_master_tx_r6: assert property (@(posedge clk) disable iff (rst)
    !slaveMode && !flags[ERR_TX] |=> !flags[ERR_TX]);
  p_master_bd_r6: assert property (@(posedge clk) disable iff (rst)
    !slaveMode && !flags[ERR_BD] |=> !flags[ERR_BD]);
  // R9: no request without an enable
  p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    !errIrq && errEnable == '0 |=> !errIrq);
endmodule

// File: tb/sim_serr_ctrl.sv
module sim_serr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          slaveMode = 1'b0;
  logic [3:0]    errEnable = '0;
  logic          evPhase = 1'b0, evTx = 1'b0, evBaud = 1'b0;
  logic          frameDone = 1'b0;
  logic [DW-1:0] frameData = '0;
  logic          bufRead = 1'b0;
  logic [3:0]    clrFlags = '0;
  logic          clrIrq = 1'b0;
  logic [3:0]    flags;
  logic          errIrq;
  logic [DW-1:0] rxBuf;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serr_ctrl #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .slaveMode(slaveMode), .errEnable(errEnable),
    .evPhase(evPhase), .evTx(evTx), .evBaud(evBaud),
    .frameDone(frameDone), .frameData(frameData), .bufRead(bufRead),
    .clrFlags(clrFlags), .clrIrq(clrIrq),
    .flags(flags), .errIrq(errIrq), .rxBuf(rxBuf)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Inputs are set just after a negedge; this lets one edge pass, then drops pulses.
  task automatic step();
    @(negedge clk);
    evPhase = 0; evTx = 0; evBaud = 0; frameDone = 0;
    bufRead = 0; clrFlags = '0; clrIrq = 0; rst = 0;
  endtask

  task automatic frame(logic [DW-1:0] d, logic rd);
    frameDone = 1; frameData = d; bufRead = rd; step();
  endtask

  task automatic wipe();
    clrFlags = '1; clrIrq = 1; step();
    bufRead = 1; step();
  endtask

  task automatic t_reset();
    check("R1 flags", flags, 0);
    check("R1 irq", errIrq, 0);
    check("R1 rxBuf", rxBuf, 0);
    frame(16'h1111, 0);
    rst = 1; step();
    check("R1 rxBuf after rst", rxBuf, 0);
    frame(16'h2222, 0);
    check("R1 unread cleared", flags[0], 0);
    frame(16'h3333, 0);
    check("R1 later overrun", flags[0], 1);
    wipe();
  endtask

  task automatic t_overrun();
    frame(16'hA5A5, 0);
    check("R3 load", rxBuf, 16'hA5A5);
    check("R2 first no err", flags, 0);
    frame(16'h5A5A, 0);
    check("R2 overrun flag", flags, 4'b0001);
    check("R3 overwrite", rxBuf, 16'h5A5A);
    wipe();
    frame(16'h0101, 0);
    bufRead = 1; step();
    frame(16'h0202, 0);
    check("R2 read then frame", flags[0], 0);
    wipe();
  endtask

  task automatic t_collide();
    frame(16'h0C0C, 0);
    frame(16'h0D0D, 1);
    check("R4 no err", flags[0], 0);
    check("R4 data", rxBuf, 16'h0D0D);
    frame(16'h0E0E, 0);
    check("R4 left unread", flags[0], 1);
    wipe();
  endtask

  task automatic t_modes();
    slaveMode = 0;
    evPhase = 1; step();
    check("R5 master phase", flags, 4'b0010);
    evTx = 1; evBaud = 1; step();
    check("R6 master ignore", flags, 4'b0010);
    wipe();
    slaveMode = 1;
    evPhase = 1; step();
    check("R5 slave phase", flags, 4'b0010);
    evTx = 1; step();
    check("R6 slave tx", flags, 4'b0110);
    evBaud = 1; step();
    check("R6 slave baud", flags, 4'b1110);
    wipe();
  endtask

  task automatic t_w1c();
    slaveMode = 1;
    evPhase = 1; evTx = 1; evBaud = 1; step();
    frame(16'h0001, 0);
    frame(16'h0002, 0);
    check("R7 all set", flags, 4'b1111);
    clrFlags = 4'b0101; step();
    check("R7 partial clear", flags, 4'b1010);
    step(); step();
    check("R7 sticky", flags, 4'b1010);
    evPhase = 1; clrFlags = 4'b0010; step();
    check("R8 set wins", flags, 4'b1010);
    wipe();
  endtask

  task automatic t_irq();
    slaveMode = 1;
    errEnable = 4'b0001;
    evPhase = 1; evTx = 1; evBaud = 1; step();
    check("R9 disabled no irq", errIrq, 0);
    check("R9 flags still set", flags, 4'b1110);
    frame(16'h0F0F, 0);
    frame(16'h0F10, 0);
    check("R9 enabled irq", errIrq, 1);
    clrFlags = '1; step();
    check("R10 irq holds", errIrq, 1);
    evPhase = 1; step();
    clrIrq = 1; step();
    check("R10 irq cleared", errIrq, 0);
    check("R10 flags kept", flags, 4'b0010);
    errEnable = 4'b0010;
    evPhase = 1; clrIrq = 1; step();
    check("R11 set wins", errIrq, 1);
    errEnable = 4'b0000;
    wipe();
    check("R10 final clear", errIrq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1; step();
    t_reset();
    t_overrun();
    t_collide();
    t_modes();
    t_w1c();
    t_irq();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule